// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

This block frees an I2C bus after a slave device has been left holding SDA low, typically because a transfer was cut off part-way through a byte. When asked to run, it looks once at the bus. If the controller reports the bus as busy, or SDA reads low, it takes the pins away from the normal I2C controller and clocks SCL by itself. Each extra clock gives the stuck slave the chance to shift out the rest of its byte and release SDA.

SDA is examined before every clock pulse, and pulsing stops as soon as SDA is seen high. Pulsing also stops once a fixed pulse limit is reached. The block then leaves SCL released for one final dwell and hands the pins back to the normal controller. It reports completion with a one-cycle done strobe and holds a recovered or failed status until the next run. When the bus is already idle, the block reports success at once and never takes the pins.

SCL is driven open-drain: the output is an active-high pull-low enable, so "SCL high" means the line is released. Every dwell interval lasts a parameterised number of clock cycles, nominally one millisecond.

Top module: `bus_unstick_seq`

## Requirements
- R1: While reset is asserted and after its release, `pin_sel_o`, `scl_oe_o`, `done_o`, `ok_o` and `fail_o` are all 0.
- R2: If `start_i` is sampled high with `busy_i` = 0 and `sda_i` = 1, the block never asserts `pin_sel_o` or `scl_oe_o`. It asserts `done_o` in the cycle after the start edge, with `ok_o` = 1 and `fail_o` = 0.
- R3: If `start_i` is sampled high with `busy_i` = 1 or `sda_i` = 0, `pin_sel_o` rises in the next cycle with `scl_oe_o` = 1 (SCL pulled low). SCL is held low for `DWELL_CYCLES` cycles before SDA is first examined.
- R4: Each recovery pulse releases SCL (`scl_oe_o` = 0) for exactly `DWELL_CYCLES` cycles and then pulls it low for `DWELL_CYCLES` cycles. One further cycle with SCL low, in which SDA is examined, comes before every pulse and after the last one.
- R5: SDA is examined in the cycle before each pulse. If it reads 1, no further pulse is issued.
- R6: At most `MAX_PULSES` (default 10) pulses are issued per run.
- R7: After the last examination, SCL is released for `DWELL_CYCLES` cycles. `pin_sel_o` then falls and `done_o` is 1 for exactly one cycle. A run with p pulses keeps `pin_sel_o` high for 2·D+1+p·(2·D+1) cycles, where D is `DWELL_CYCLES`.
- R8: `fail_o` = 1 if SDA is still 0 at the examination that follows the final allowed pulse; otherwise `ok_o` = 1. The two are never both 1. Both are cleared when a run starts and are held after `done_o` until the next start.
- R9: `start_i` is ignored while a run is in progress: it causes no extra pulse and no second `done_o`.
- R10: `scl_oe_o` is only ever 1 while `pin_sel_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a bus check and, if needed, a recovery run |
| busy_i | input | 1 | Busy indication from the normal I2C controller |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | Open-drain SCL enable, 1 pulls SCL low |
| pin_sel_o | output | 1 | 1 gives the pins to this block, 0 to the normal controller |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | Bus found idle or recovered (held) |
| fail_o | output | 1 | SDA still low after the pulse limit (held) |

## Verification
A corrupted phase state or dwell counter shows up directly on `scl_oe_o`. The effect is either a high or low phase whose length is not exactly D cycles, which is visible within one dwell, or a run whose `pin_sel_o` duration departs from 2·D+1+p·(2·D+1). A broken pulse counter or SDA check shows up as a wrong number of SCL rising edges by the end of the run, or as the wrong status bit on `done_o`. A stuck ownership path shows as `scl_oe_o` active without `pin_sel_o`, or as `pin_sel_o` still high after `done_o`, both in the first affected cycle.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_CHECK = 3'd2,
        ST_HIGH  = 3'd3,
        ST_LOW   = 3'd4,
        ST_TAIL  = 3'd5,
        ST_FIN   = 3'd6
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   ok;
        logic   fail;
    } seq_state_t;

    function automatic logic phase_is_timed(phase_e p);
        return (p == ST_PRE) || (p == ST_HIGH) || (p == ST_LOW) || (p == ST_TAIL);
    endfunction

endpackage

// File: rtl/unstick_dwell_timer.sv
module unstick_dwell_timer #(
    parameter int unsigned DWELL_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    assign at_last   = (cnt_q == LAST);
    assign expired_o = run_i && at_last;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || at_last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/unstick_pulse_counter.sv
module unstick_pulse_counter #(
    parameter int unsigned MAX_PULSES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);
    localparam int unsigned PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

    logic [PW-1:0] cnt_d, cnt_q;

    assign at_limit_o = (cnt_q == LIMIT);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && !at_limit_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import unstick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    input  logic sda_i,
    input  logic expired_i,
    input  logic at_limit_i,
    output logic timer_run_o,
    output logic cnt_clr_o,
    output logic cnt_inc_o,
    output logic scl_oe_o,
    output logic pin_sel_o,
    output logic done_o,
    output logic ok_o,
    output logic fail_o
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (st_q.phase)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.ok   = 1'b0;
                    st_d.fail = 1'b0;
                    cnt_clr_o = 1'b1;
                    if (busy_i || !sda_i) begin
                        st_d.phase = ST_PRE;
                    end else begin
                        st_d.phase = ST_FIN;
                        st_d.ok    = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (expired_i) st_d.phase = ST_CHECK;
            end
            ST_CHECK: begin
                if (sda_i) begin
                    st_d.phase = ST_TAIL;
                    st_d.ok    = 1'b1;
                end else if (at_limit_i) begin
                    st_d.phase = ST_TAIL;
                    st_d.fail  = 1'b1;
                end else begin
                    st_d.phase = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (expired_i) begin
                    st_d.phase = ST_LOW;
                    cnt_inc_o  = 1'b1;
                end
            end
            ST_LOW: begin
                if (expired_i) st_d.phase = ST_CHECK;
            end
            ST_TAIL: begin
                if (expired_i) st_d.phase = ST_FIN;
            end
            ST_FIN: begin
                st_d.phase = ST_IDLE;
            end
            default: begin
                st_d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: ST_IDLE, ok: 1'b0, fail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign timer_run_o = phase_is_timed(st_q.phase);
    assign pin_sel_o   = (st_q.phase != ST_IDLE) && (st_q.phase != ST_FIN);
    assign scl_oe_o    = (st_q.phase == ST_PRE) || (st_q.phase == ST_CHECK) ||
                         (st_q.phase == ST_LOW);
    assign done_o      = (st_q.phase == ST_FIN);
    assign ok_o        = st_q.ok;
    assign fail_o      = st_q.fail;
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq #(
    parameter int unsigned DWELL_CYCLES = 125000,
    parameter int unsigned MAX_PULSES   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic pin_sel_o,
    output logic done_o,
    output logic ok_o,
    output logic fail_o
);
    logic timer_run, expired, cnt_clr, cnt_inc, at_limit;

    unstick_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (timer_run),
        .expired_o (expired)
    );

    unstick_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr),
        .inc_i      (cnt_inc),
        .at_limit_o (at_limit)
    );

    unstick_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .busy_i      (busy_i),
        .sda_i       (sda_i),
        .expired_i   (expired),
        .at_limit_i  (at_limit),
        .timer_run_o (timer_run),
        .cnt_clr_o   (cnt_clr),
        .cnt_inc_o   (cnt_inc),
        .scl_oe_o    (scl_oe_o),
        .pin_sel_o   (pin_sel_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .fail_o      (fail_o)
    );
endmodule

// File: rtl/unstick_props.sv
module unstick_props #(
    parameter int unsigned DWELL_CYCLES = 125000,
    parameter int unsigned MAX_PULSES   = 10
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_oe_o,
    input logic pin_sel_o,
    input logic done_o,
    input logic ok_o,
    input logic fail_o
);
    int unsigned hi_len_q;
    int unsigned rises_q;
    logic        oe_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q  <= 0;
            rises_q   <= 0;
            oe_prev_q <= 1'b0;
        end else begin
            hi_len_q  <= (pin_sel_o && !scl_oe_o) ? hi_len_q + 1 : 0;
            oe_prev_q <= scl_oe_o;
            if (!pin_sel_o)                   rises_q <= 0;
            else if (oe_prev_q && !scl_oe_o)  rises_q <= rises_q + 1;
        end
    end

    // R10
    a_r10_scl_needs_pins: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> pin_sel_o);

    // R7
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_pins_back: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pin_sel_o);

    // R8
    a_r8_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && fail_o));

    // R9: ownership can only be taken in response to a start request
    a_r9_take_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_sel_o) |-> $past(start_i));

    // R4: every released phase inside a run lasts one dwell
    a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel_o && scl_oe_o && hi_len_q != 0) |-> (hi_len_q == DWELL_CYCLES));

    // R6: pulses plus the closing release never exceed the limit plus one
    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= MAX_PULSES + 1);
endmodule

bind bus_unstick_seq unstick_props #(
    .DWELL_CYCLES(DWELL_CYCLES),
    .MAX_PULSES  (MAX_PULSES)
) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .scl_oe_o  (scl_oe_o),
    .pin_sel_o (pin_sel_o),
    .done_o    (done_o),
    .ok_o      (ok_o),
    .fail_o    (fail_o)
);

// File: tb/tb_bus_unstick_seq.sv
module tb_bus_unstick_seq;
    localparam int D    = 4;
    localparam int MAXP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_i = 1'b0;
    logic sda_i;
    logic scl_oe_o, pin_sel_o, done_o, ok_o, fail_o;

    always #4 clk = ~clk;

    bus_unstick_seq #(.DWELL_CYCLES(D), .MAX_PULSES(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i), .sda_i(sda_i),
        .scl_oe_o(scl_oe_o), .pin_sel_o(pin_sel_o), .done_o(done_o),
        .ok_o(ok_o), .fail_o(fail_o)
    );

    int tests = 0;
    int fails = 0;
    logic clr_mon = 1'b1;
    int k_tgt = 0;
    int psel_cyc, stray, rises, done_cnt, cyc;
    logic prev_oe;
    logic finished = 1'b0;

    // slave model: lets SDA go after k_tgt SCL rising edges
    assign sda_i = (rises >= k_tgt);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_mon) begin
            psel_cyc <= 0; stray <= 0; rises <= 0; done_cnt <= 0; prev_oe <= 1'b0;
        end else begin
            if (pin_sel_o) psel_cyc <= psel_cyc + 1;
            if (scl_oe_o && !pin_sel_o) stray <= stray + 1;
            if (prev_oe && !scl_oe_o) rises <= rises + 1;
            if (done_o) done_cnt <= done_cnt + 1;
            prev_oe <= scl_oe_o;
        end
    end

    initial begin
        cyc = 0; psel_cyc = 0; stray = 0; rises = 0; done_cnt = 0; prev_oe = 1'b0;
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // columns: busy, SCL rises before slave lets go, expected pulses, ok, pins taken
    localparam int NV = 8;
    localparam int VT [NV][5] = '{
        '{0,  0,  0, 1, 0},
        '{1,  0,  0, 1, 1},
        '{0,  1,  1, 1, 1},
        '{1,  3,  3, 1, 1},
        '{0,  9,  9, 1, 1},
        '{1, 10, 10, 1, 1},
        '{0, 11, 10, 0, 1},
        '{1, 40, 10, 0, 1}
    };

    task automatic run_vec(input int busy, input int k, input int ep, input int eok,
                           input int erec, input int inject, input string tag);
        int lat;
        int exp_t;
        bit seen;
        @(negedge clk);
        busy_i = busy[0]; k_tgt = k; clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0; start_i = 1'b1;
        lat = 0; seen = 1'b0;
        while (!seen && lat < 2000) begin
            @(negedge clk);
            lat++;
            start_i = (inject > 0 && lat == inject);
            if (done_o) seen = 1'b1;
        end
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        busy_i = 1'b0;
        exp_t = erec ? (2*D + 1 + ep*(2*D + 1)) : 0;
        if (erec == 0) begin
            // R2: idle bus, done next cycle, pins never taken
            chk(lat == 1, {"R2 latency ", tag}, lat, 1);
            chk(psel_cyc == 0 && rises == 0, {"R2 pins untouched ", tag}, psel_cyc, 0);
        end else begin
            // R3/R4/R7: total ownership time and latency
            chk(psel_cyc == exp_t, {"R7 owned cycles ", tag}, psel_cyc, exp_t);
            chk(lat == exp_t + 1, {"R4 done latency ", tag}, lat, exp_t + 1);
            // R5/R6: pulses plus the closing release
            chk(rises == ep + 1, {"R6 R5 scl rises ", tag}, rises, ep + 1);
        end
        chk(ok_o == eok[0] && fail_o == !eok[0], {"R8 status ", tag}, {ok_o, fail_o}, eok ? 2 : 1);
        chk(done_cnt == 1, {"R7 R9 done count ", tag}, done_cnt, 1);
        chk(stray == 0, {"R10 scl without pins ", tag}, stray, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk({pin_sel_o, scl_oe_o, done_o, ok_o, fail_o} == 5'b0, "R1 in reset",
            {pin_sel_o, scl_oe_o, done_o, ok_o, fail_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({pin_sel_o, scl_oe_o, done_o, ok_o, fail_o} == 5'b0, "R1 after reset",
            {pin_sel_o, scl_oe_o, done_o, ok_o, fail_o}, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], 0,
                    $sformatf("vec%0d", i));
        end

        // R3: first cycle after start pulls SCL low with pins taken
        @(negedge clk);
        busy_i = 1'b1; k_tgt = 2; clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(pin_sel_o && scl_oe_o, "R3 takeover", {pin_sel_o, scl_oe_o}, 3);
        repeat (D - 1) @(negedge clk);
        chk(scl_oe_o, "R3 low dwell", scl_oe_o, 1);
        repeat (200) @(negedge clk);
        busy_i = 1'b0;

        // R9: start pulses in the middle of runs are ignored
        run_vec(0, 3, 3, 1, 1, 12, "R9 mid-pulse");
        run_vec(1, 11, 10, 0, 1, 50, "R9 late");
        // R8: status of a failed run is replaced after the next good run
        run_vec(0, 0, 0, 1, 0, 0, "R8 after fail");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule